// File: doc/BRIEF.md
# Log-MAP Add-Compare-Select-Add Unit

This block performs one state-metric update of a radix-2 trellis recursion in the log domain. Two incoming branches reach a state. For each branch the unit adds the previous metric of the source state to the branch metric and saturates the sum. It then keeps the larger of the two candidates. A small correction table, indexed by the distance between the candidates, supplies an approximation of log(1+exp(-|d|)). That correction is added to the larger candidate, so the unit computes max* instead of the plain maximum of a Viterbi unit. The new metric is registered, giving one result per cycle.

The block has no notion of direction. A forward recursion and a backward recursion instantiate it unchanged and differ only in how they wire the metrics to it. Metrics are narrow unsigned fixed-point words with two fractional bits. They saturate at the top of the range. A normalize request lowers the result by a fixed offset, so a recursion whose metrics climb can be pulled back down. A parameter can remove the correction table, which turns the unit into a plain max selector.

Top module: `logmap_acsa`

## Requirements
- R1: Each candidate is `sm + bm` for its branch. The sum saturates at 2^MW-1 (63 for the default MW=6).
- R2: The unit selects the larger of the two saturated candidates. When the candidates are equal, either one gives the same value.
- R3: The correction index is the absolute difference of the saturated candidates, clamped to 2^LUT_AW-1. The correction is 3 for index 0, 2 for index 1 to 3, 1 for index 4 to 8, and 0 for larger indices. CORR_EN=1 is the default.
- R4: The pre-normalize result is the selected candidate plus the correction, saturated at 2^MW-1.
- R5: When `norm_i` is high together with `vld_i`, NORM_SUB is subtracted from the result, and the result does not go below zero. NORM_SUB defaults to 16.
- R6: `sm_o` shows the result of the inputs from the previous clock edge. `vld_o` is `vld_i` delayed by one cycle.
- R7: While `vld_i` is low, `sm_o` holds its value. The data inputs and `norm_i` then have no effect.
- R8: During reset `sm_o` is 0 and `vld_o` is 0.
- R9: Swapping the two branch pairs (sm0,bm0) and (sm1,bm1) gives the same result. This is what allows one unit to serve both recursion directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input metrics valid; loads a new result |
| norm_i | input | 1 | Subtract the normalization offset from this result |
| sm0_i | input | MW | Previous state metric, branch 0 |
| bm0_i | input | MW | Branch metric, branch 0 |
| sm1_i | input | MW | Previous state metric, branch 1 |
| bm1_i | input | MW | Branch metric, branch 1 |
| sm_o | output | MW | New state metric, registered |
| vld_o | output | 1 | Result valid |

## Verification
The assertions only hold if `vld_i` and `norm_i` are defined from reset onwards. They also expect the metric inputs to be stable around the sampling edge, because bounds are compared against the candidates of the previous cycle. The bench satisfies both conditions. It drives every input only on the falling edge and holds the control inputs low from time zero. The stimulus sweeps the full range of both state metrics under several branch-metric patterns. This covers equal candidates, every index in the correction table, and sums that saturate.

// File: rtl/acsa_pkg.sv
package acsa_pkg;

   // Correction step levels for metrics with two fractional bits
   localparam int unsigned CORR_W    = 2;
   localparam int unsigned CORR_TOP  = 3;
   localparam int unsigned STEP_HI   = 3;   // last index giving 2
   localparam int unsigned STEP_LO   = 8;   // last index giving 1

   function automatic int unsigned corr_step(int unsigned d);
      if (d == 0)       return CORR_TOP;
      if (d <= STEP_HI) return 2;
      if (d <= STEP_LO) return 1;
      return 0;
   endfunction

endpackage

// File: rtl/acsa_cand_add.sv
module acsa_cand_add #(
   parameter int MW = 6
) (
   input  logic [MW-1:0] sm_i,
   input  logic [MW-1:0] bm_i,
   output logic [MW-1:0] cand_o
);
   logic [MW:0] sum_w;

   assign sum_w  = {1'b0, sm_i} + {1'b0, bm_i};
   assign cand_o = sum_w[MW] ? {MW{1'b1}} : sum_w[MW-1:0];
endmodule

// File: rtl/acsa_cmp_sel.sv
module acsa_cmp_sel #(
   parameter int MW = 6,
   parameter int AW = 4
) (
   input  logic [MW-1:0] c0_i,
   input  logic [MW-1:0] c1_i,
   output logic [MW-1:0] max_o,
   output logic [AW-1:0] idx_o
);
   localparam int DW = (MW > AW) ? MW : AW;
   localparam logic [DW-1:0] IDX_MAX = DW'((1 << AW) - 1);

   logic          c0_ge;
   logic [MW-1:0] diff;
   logic [DW-1:0] diff_w;

   assign c0_ge  = (c0_i >= c1_i);
   assign max_o  = c0_ge ? c0_i : c1_i;
   assign diff   = c0_ge ? (c0_i - c1_i) : (c1_i - c0_i);
   assign diff_w = DW'(diff);
   assign idx_o  = (diff_w > IDX_MAX) ? AW'(IDX_MAX) : AW'(diff_w);
endmodule

// File: rtl/acsa_corr_lut.sv
module acsa_corr_lut #(
   parameter int AW      = 4,
   parameter int CW      = 2,
   parameter bit CORR_EN = 1'b1
) (
   input  logic [AW-1:0] idx_i,
   output logic [CW-1:0] corr_o
);
   localparam int DEPTH = 1 << AW;

   generate
      if (CORR_EN) begin : g_table
         logic [CW-1:0] tbl [DEPTH];
         for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            assign tbl[g] = CW'(acsa_pkg::corr_step(g));
         end
         assign corr_o = tbl[idx_i];
      end else begin : g_plain
         logic unused_idx;
         assign unused_idx = ^idx_i;
         assign corr_o     = '0;
      end
   endgenerate
endmodule

// File: rtl/logmap_acsa.sv
module logmap_acsa #(
   parameter int MW       = 6,
   parameter int LUT_AW   = 4,
   parameter int NORM_SUB = 16,
   parameter bit CORR_EN  = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          vld_i,
   input  logic          norm_i,
   input  logic [MW-1:0] sm0_i,
   input  logic [MW-1:0] bm0_i,
   input  logic [MW-1:0] sm1_i,
   input  logic [MW-1:0] bm1_i,
   output logic [MW-1:0] sm_o,
   output logic          vld_o
);
   localparam int CW   = acsa_pkg::CORR_W;
   localparam int NBR  = 2;
   localparam logic [MW-1:0] SUB_V = MW'(NORM_SUB);

   generate
      if (MW < 3 || MW > 12) begin : g_bad_mw
         $error("logmap_acsa: MW must lie in 3..12");
      end
      if (CORR_EN && (LUT_AW < 4)) begin : g_bad_aw
         $error("logmap_acsa: LUT_AW must cover the nonzero correction span");
      end
      if (NORM_SUB < 1 || NORM_SUB >= (1 << MW)) begin : g_bad_sub
         $error("logmap_acsa: NORM_SUB out of range");
      end
   endgenerate

   logic [MW-1:0] sm_a   [NBR];
   logic [MW-1:0] bm_a   [NBR];
   logic [MW-1:0] cand_a [NBR];

   assign sm_a[0] = sm0_i;
   assign sm_a[1] = sm1_i;
   assign bm_a[0] = bm0_i;
   assign bm_a[1] = bm1_i;

   generate
      for (genvar b = 0; b < NBR; b++) begin : g_br
         acsa_cand_add #(.MW(MW)) u_add (
            .sm_i   (sm_a[b]),
            .bm_i   (bm_a[b]),
            .cand_o (cand_a[b])
         );
      end
   endgenerate

   logic [MW-1:0]     max_w;
   logic [LUT_AW-1:0] idx_w;
   logic [CW-1:0]     corr_w;

   acsa_cmp_sel #(.MW(MW), .AW(LUT_AW)) u_cmp (
      .c0_i  (cand_a[0]),
      .c1_i  (cand_a[1]),
      .max_o (max_w),
      .idx_o (idx_w)
   );

   acsa_corr_lut #(.AW(LUT_AW), .CW(CW), .CORR_EN(CORR_EN)) u_lut (
      .idx_i  (idx_w),
      .corr_o (corr_w)
   );

   logic [MW:0]   fin_sum;
   logic [MW-1:0] fin_sat;
   logic [MW-1:0] nxt_sm;

   assign fin_sum = {1'b0, max_w} + (MW+1)'(corr_w);
   assign fin_sat = fin_sum[MW] ? {MW{1'b1}} : fin_sum[MW-1:0];

   always_comb begin
      nxt_sm = fin_sat;
      if (norm_i) begin
         nxt_sm = (fin_sat >= SUB_V) ? (fin_sat - SUB_V) : '0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sm_o  <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) sm_o <= nxt_sm;
      end
   end
endmodule

// File: rtl/acsa_chk.sv
module acsa_chk #(
   parameter int MW       = 6,
   parameter int NORM_SUB = 16
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          vld_i,
   input logic          norm_i,
   input logic [MW-1:0] sm0_i,
   input logic [MW-1:0] bm0_i,
   input logic [MW-1:0] sm1_i,
   input logic [MW-1:0] bm1_i,
   input logic [MW-1:0] sm_o,
   input logic          vld_o
);
   localparam int TOP = (1 << MW) - 1;

   int   c0, c1, cmax;
   logic armed;

   always_comb begin
      c0   = int'(sm0_i) + int'(bm0_i);
      c1   = int'(sm1_i) + int'(bm1_i);
      if (c0 > TOP) c0 = TOP;
      if (c1 > TOP) c1 = TOP;
      cmax = (c0 > c1) ? c0 : c1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed <= 1'b0;
      else         armed <= 1'b1;
   end

   AST_VLD_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      vld_o == $past(vld_i)); // R6
   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      !$past(vld_i) |-> $stable(sm_o)); // R7
   AST_MAX_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      $past(vld_i && !norm_i) |-> int'(sm_o) >= $past(cmax)); // R2
   AST_CORR_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      $past(vld_i && !norm_i) |-> int'(sm_o) <= $past(cmax) + 3); // R3
   AST_NORM_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
      $past(vld_i && norm_i) |-> int'(sm_o) <= TOP - NORM_SUB); // R5

   always @(negedge clk_i) begin
      if (!rst_ni) begin
         AST_RST_CLEAR: assert (sm_o == '0 && !vld_o); // R8
      end
   end
endmodule

bind logmap_acsa acsa_chk #(.MW(MW), .NORM_SUB(NORM_SUB)) u_acsa_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .vld_i  (vld_i),
   .norm_i (norm_i),
   .sm0_i  (sm0_i),
   .bm0_i  (bm0_i),
   .sm1_i  (sm1_i),
   .bm1_i  (bm1_i),
   .sm_o   (sm_o),
   .vld_o  (vld_o)
);

// File: tb/tb_logmap_acsa.sv
module tb_logmap_acsa;
   localparam int MW  = 6;
   localparam int TOP = 63;
   localparam int SUB = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vld = 1'b0;
   logic          norm = 1'b0;
   logic [MW-1:0] sm0 = '0, bm0 = '0, sm1 = '0, bm1 = '0;
   logic [MW-1:0] sm_o;
   logic          vld_o;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   logmap_acsa dut (
      .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .norm_i(norm),
      .sm0_i(sm0), .bm0_i(bm0), .sm1_i(sm1), .bm1_i(bm1),
      .sm_o(sm_o), .vld_o(vld_o)
   );

   function automatic int ref_acsa(int a0, int b0, int a1, int b1, bit nz);
      int c0, c1, m, d, cr, r;
      c0 = a0 + b0; if (c0 > TOP) c0 = TOP;
      c1 = a1 + b1; if (c1 > TOP) c1 = TOP;
      m  = (c0 > c1) ? c0 : c1;
      d  = (c0 > c1) ? c0 - c1 : c1 - c0;
      if (d > 15) d = 15;
      cr = (d == 0) ? 3 : (d <= 3) ? 2 : (d <= 8) ? 1 : 0;
      r  = m + cr; if (r > TOP) r = TOP;
      if (nz) r = (r >= SUB) ? r - SUB : 0;
      return r;
   endfunction

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic apply(string req, int a0, int b0, int a1, int b1, bit nz);
      sm0 = MW'(a0); bm0 = MW'(b0); sm1 = MW'(a1); bm1 = MW'(b1);
      norm = nz; vld = 1'b1;
      @(negedge clk);
      chk(req, int'(sm_o), ref_acsa(a0, b0, a1, b1, nz));
      chk("R6 vld_o", int'(vld_o), 1);
   endtask

   initial begin
      #2_000_000;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int keep, r_a, r_b;
      @(negedge clk); @(negedge clk);
      chk("R8 reset sm_o", int'(sm_o), 0);
      chk("R8 reset vld_o", int'(vld_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R4 both candidates saturate, equal -> corr 3, capped
      apply("R1 R4 saturate", 63, 63, 60, 20, 1'b0);
      // R2 tie: 15 vs 15 -> 18
      apply("R2 tie", 10, 5, 12, 3, 1'b0);
      // R3 index 8 -> +1, index 9 -> +0
      apply("R3 diff8", 20, 0, 12, 0, 1'b0);
      apply("R3 diff9", 20, 0, 11, 0, 1'b0);
      apply("R3 diff3", 7, 4, 8, 0, 1'b0);
      // R5 floor at zero and ordinary subtract
      apply("R5 floor", 2, 1, 0, 3, 1'b1);
      apply("R5 subtract", 40, 5, 30, 0, 1'b1);

      // R7 idle: changed data and norm have no effect
      keep = int'(sm_o);
      sm0 = 6'd1; bm0 = 6'd50; sm1 = 6'd9; bm1 = 6'd2; norm = 1'b1; vld = 1'b0;
      @(negedge clk);
      chk("R7 hold", int'(sm_o), keep);
      chk("R6 vld_o low", int'(vld_o), 0);
      @(negedge clk);
      chk("R7 hold2", int'(sm_o), keep);

      // R1-style sweep over both state metrics, several branch patterns (R2 R3 R4 R5)
      for (int a = 0; a < 64; a++) begin
         for (int b = 0; b < 64; b++) begin
            int p0, p1;
            if (((a + b) % 3) == 0) begin
               p0 = (a * 5 + b * 3) % 64;
               p1 = (a * 11 + b * 7 + 1) % 64;
            end else begin
               p0 = (a + b) % 8;
               p1 = ((a * 3) ^ b) % 8;
            end
            apply("R4 sweep", a, p0, b, p1, ((a * 64 + b) % 17) == 0);
         end
      end

      // R9 branch swap symmetry
      for (int k = 0; k < 40; k++) begin
         int a0, b0, a1, b1;
         a0 = (k * 13) % 64; b0 = (k * 5) % 16;
         a1 = (k * 29 + 3) % 64; b1 = (k * 7) % 16;
         apply("R9 direct", a0, b0, a1, b1, 1'b0);
         r_a = int'(sm_o);
         apply("R9 swapped", a1, b1, a0, b0, 1'b0);
         r_b = int'(sm_o);
         chk("R9 symmetry", r_b, r_a);
      end

      vld = 1'b0; norm = 1'b0;
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule